// File: doc/BRIEF.md
# Fetch Redirect and Squash Unit

This block is the fetch-stage control of a four-stage in-order pipeline. It owns the fetch program counter and the instruction register at the front of the register-read stage. In every cycle it picks the next fetch address from one of five sources: the sequential address, a branch target, a jump target, the illegal-operation vector or the interrupt vector.

Branches and jumps are resolved while they sit in the register-read stage. By then, one further instruction has already been fetched. When a branch or jump is taken, the block does not let that instruction run. It writes a harmless add-to-register-31 word into the register-read instruction register in its place. That word writes no register and no memory. Software therefore sees no delay slot.

The branch target is formed from the stored link value of the branch instruction (its address plus 4) and the instruction's 16-bit word offset. Decoding of taken branches, jumps, illegal opcodes and interrupts happens outside the block and arrives as single-bit requests.

Top module: `fetch_redirect`

## Requirements
- R1: A synchronous active-high reset sets `pc_o` to 0, `rf_link_o` to 0 and `rf_instr_o` to the squash word 0x83FFF800. The squash word has opcode 0x20 in bits 31:26 and the value 31 in each of the fields 25:21, 20:16 and 15:11.
- R2: When there is no stall and no redirect, `pc_o` advances by 4 at each clock. On the same clock, `rf_instr_o` takes the previous `if_instr_i` and `rf_link_o` takes the previous `pc_o`+4.
- R3: A taken branch (`br_taken_i`) gives `next_pc_o` = `rf_link_o` + (sign-extended `rf_instr_o[15:0]` << 2), and `pc_o` loads that value at the next clock. This holds for both positive and negative offsets.
- R4: A jump (`jmp_i`) gives `next_pc_o` = `jmp_tgt_i` with bits 1:0 cleared, and `pc_o` loads that value at the next clock.
- R5: An illegal-operation request (`illop_i`) selects the address parameter `ILL_VEC` (default 0x4). An interrupt request (`irq_i`) selects the address parameter `IRQ_VEC` (default 0x8).
- R6: `pc_sel_o` reports the chosen source: 0 sequential, 1 branch, 2 jump, 3 illegal-operation, 4 interrupt. When several requests are active, the priority order is interrupt, then illegal-operation, then jump, then branch.
- R7: `annul_o` is 1 exactly when `pc_sel_o` is 1 or 2. When it is 1, `rf_instr_o` holds 0x83FFF800 after the next clock.
- R8: While `stall_i` is 1 and `pc_sel_o` is 0, `pc_o`, `rf_instr_o` and `rf_link_o` keep their values.
- R9: A taken branch or jump during a stall still loads the target into `pc_o` and the squash word into `rf_instr_o`. A trap during a stall loads its vector into `pc_o` and leaves `rf_instr_o` unchanged.
- R10: Bits 1:0 of `pc_o` and `next_pc_o` are always 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze fetch and register-read stage |
| if_instr_i | input | 32 | Instruction word fetched at `pc_o` |
| br_taken_i | input | 1 | Branch in register-read stage is taken |
| jmp_i | input | 1 | Jump in register-read stage |
| jmp_tgt_i | input | AW | Jump target address |
| illop_i | input | 1 | Illegal-operation trap request |
| irq_i | input | 1 | External interrupt request |
| pc_o | output | AW | Current fetch address |
| next_pc_o | output | AW | Address chosen for the next fetch |
| pc_sel_o | output | 3 | Chosen source code |
| annul_o | output | 1 | Fetched instruction is being squashed |
| rf_instr_o | output | 32 | Register-read stage instruction |
| rf_link_o | output | AW | Register-read stage instruction address plus 4 |

## Verification
Each of the three state registers shows a fault at the ports within one clock.

- A wrong program counter appears in `pc_o` on the clock after it is loaded. It also shifts every sequential and branch target computed after that point.
- A squash that does not happen leaves the prefetched word, not 0x83FFF800, in `rf_instr_o` one clock after `annul_o`.
- A wrong link value appears in `rf_link_o` directly. It also shows as a branch target that is off by the same amount.

Priority and encoding errors show in the same cycle on `pc_sel_o` and `next_pc_o`.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int IW = 32;
  localparam int LW = 16;

  typedef enum logic [2:0] {
    SEL_SEQ = 3'd0,
    SEL_BR  = 3'd1,
    SEL_JMP = 3'd2,
    SEL_ILL = 3'd3,
    SEL_IRQ = 3'd4
  } pc_sel_e;

  // squash word: add with every register field pointing at r31
  function automatic logic [IW-1:0] squash_word(input logic [5:0] op);
    return {op, 5'd31, 5'd31, 5'd31, 11'd0};
  endfunction
endpackage

// File: rtl/fr_pc_select.sv
module fr_pc_select
  import fr_pkg::*;
(
  input  logic    irq,
  input  logic    illop,
  input  logic    jmp,
  input  logic    br,
  output pc_sel_e sel,
  output logic    squash
);
  always_comb begin
    if (irq)        sel = SEL_IRQ;
    else if (illop) sel = SEL_ILL;
    else if (jmp)   sel = SEL_JMP;
    else if (br)    sel = SEL_BR;
    else            sel = SEL_SEQ;
  end

  assign squash = (sel == SEL_BR) || (sel == SEL_JMP);
endmodule

// File: rtl/fr_target_gen.sv
module fr_target_gen #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [AW-1:0] link,
  input  logic [LW-1:0] offset,
  output logic [AW-1:0] target
);
  localparam int EXT = AW - LW - 2;

  logic [AW-1:0] byte_off;

  generate
    if (EXT > 0) begin : g_ext
      assign byte_off = {{EXT{offset[LW-1]}}, offset, 2'b00};
    end else begin : g_trunc
      assign byte_off = AW'({offset, 2'b00});
    end
  endgenerate

  assign target = link + byte_off;
endmodule

// File: rtl/fr_rf_stage.sv
module fr_rf_stage #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter logic [IW-1:0] SQUASH = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          squash,
  input  logic [IW-1:0] fetched,
  input  logic [AW-1:0] link_in,
  output logic [IW-1:0] instr,
  output logic [AW-1:0] link
);
  always_ff @(posedge clk) begin
    if (rst) begin
      instr <= SQUASH;
      link  <= '0;
    end else if (squash) begin
      instr <= SQUASH;
      link  <= link_in;
    end else if (!stall) begin
      instr <= fetched;
      link  <= link_in;
    end
  end
endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fr_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] ILL_VEC = 'h4,
  parameter logic [AW-1:0] IRQ_VEC = 'h8,
  parameter logic [5:0] ADD_OP = 6'h20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall_i,
  input  logic [31:0]   if_instr_i,
  input  logic          br_taken_i,
  input  logic          jmp_i,
  input  logic [AW-1:0] jmp_tgt_i,
  input  logic          illop_i,
  input  logic          irq_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] next_pc_o,
  output logic [2:0]    pc_sel_o,
  output logic          annul_o,
  output logic [31:0]   rf_instr_o,
  output logic [AW-1:0] rf_link_o
);
  localparam logic [IW-1:0] SQUASH = squash_word(ADD_OP);
  localparam logic [AW-1:0] ALIGN  = ~AW'(3);

  pc_sel_e       sel;
  logic          squash;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_plus4;
  logic [AW-1:0] br_tgt;
  logic [AW-1:0] raw_next;
  logic          pc_load;

  fr_pc_select u_sel (
    .irq    (irq_i),
    .illop  (illop_i),
    .jmp    (jmp_i),
    .br     (br_taken_i),
    .sel    (sel),
    .squash (squash)
  );

  fr_target_gen #(.AW(AW), .LW(LW)) u_tgt (
    .link   (rf_link_o),
    .offset (rf_instr_o[LW-1:0]),
    .target (br_tgt)
  );

  assign pc_plus4 = pc_q + AW'(4);

  always_comb begin
    case (sel)
      SEL_BR:  raw_next = br_tgt;
      SEL_JMP: raw_next = jmp_tgt_i;
      SEL_ILL: raw_next = ILL_VEC;
      SEL_IRQ: raw_next = IRQ_VEC;
      default: raw_next = pc_plus4;
    endcase
  end

  assign next_pc_o = raw_next & ALIGN;
  assign pc_load   = !stall_i || (sel != SEL_SEQ);

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (pc_load) pc_q <= next_pc_o;
  end

  fr_rf_stage #(.AW(AW), .IW(IW), .SQUASH(SQUASH)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .stall   (stall_i),
    .squash  (squash),
    .fetched (if_instr_i),
    .link_in (pc_plus4),
    .instr   (rf_instr_o),
    .link    (rf_link_o)
  );

  assign pc_o     = pc_q;
  assign pc_sel_o = sel;
  assign annul_o  = squash;
endmodule

// File: rtl/fetch_redirect_chk.sv
module fetch_redirect_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          stall_i,
  input logic          irq_i,
  input logic          illop_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] next_pc_o,
  input logic [2:0]    pc_sel_o,
  input logic          annul_o,
  input logic [31:0]   rf_instr_o,
  input logic [AW-1:0] rf_link_o
);
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00); // R10

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && pc_sel_o == 3'd0) |=> pc_o == $past(pc_o) + AW'(4)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall_i && pc_sel_o == 3'd0) |=> ($stable(pc_o) && $stable(rf_instr_o) && $stable(rf_link_o))); // R8

  AST_ANNUL_SQUASH: assert property (@(posedge clk) disable iff (rst)
    annul_o |=> rf_instr_o == 32'h83FF_F800); // R7

  AST_REDIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (pc_sel_o != 3'd0) |=> pc_o == $past(next_pc_o)); // R9

  AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (rst)
    irq_i |-> (pc_sel_o == 3'd4 && !annul_o)); // R6

  AST_ILL_SECOND: assert property (@(posedge clk) disable iff (rst)
    (illop_i && !irq_i) |-> pc_sel_o == 3'd3); // R6
endmodule

bind fetch_redirect fetch_redirect_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stall_i    (stall_i),
  .irq_i      (irq_i),
  .illop_i    (illop_i),
  .pc_o       (pc_o),
  .next_pc_o  (next_pc_o),
  .pc_sel_o   (pc_sel_o),
  .annul_o    (annul_o),
  .rf_instr_o (rf_instr_o),
  .rf_link_o  (rf_link_o)
);

// File: tb/fetch_redirect_tb.sv
module fetch_redirect_tb;
  localparam logic [31:0] SQ = 32'h83FF_F800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 1'b0;
  logic [31:0] if_instr_i = '0;
  logic        br_taken_i = 1'b0;
  logic        jmp_i = 1'b0;
  logic [31:0] jmp_tgt_i = '0;
  logic        illop_i = 1'b0;
  logic        irq_i = 1'b0;
  logic [31:0] pc_o, next_pc_o, rf_instr_o, rf_link_o;
  logic [2:0]  pc_sel_o;
  logic        annul_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fetch_redirect u_dut (
    .clk(clk), .rst(rst), .stall_i(stall_i), .if_instr_i(if_instr_i),
    .br_taken_i(br_taken_i), .jmp_i(jmp_i), .jmp_tgt_i(jmp_tgt_i),
    .illop_i(illop_i), .irq_i(irq_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
    .pc_sel_o(pc_sel_o), .annul_o(annul_o), .rf_instr_o(rf_instr_o),
    .rf_link_o(rf_link_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_req();
    br_taken_i = 0; jmp_i = 0; illop_i = 0; irq_i = 0; stall_i = 0;
  endtask

  task automatic t_reset();
    rst = 1; clear_req();
    step(); step();
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 instr", rf_instr_o, SQ);
    chk("R1 link", rf_link_o, 32'h0);
    rst = 0;
  endtask

  task automatic t_sequential();
    logic [31:0] p;
    for (int i = 0; i < 3; i++) begin
      p = pc_o;
      if_instr_i = 32'hA000_0000 + i;
      #1;
      chk("R6 seq sel", {29'd0, pc_sel_o}, 32'd0);
      chk("R7 seq annul", {31'd0, annul_o}, 32'd0);
      step();
      chk("R2 pc", pc_o, p + 4);
      chk("R2 instr", rf_instr_o, 32'hA000_0000 + i);
      chk("R2 link", rf_link_o, p + 4);
      chk("R10 align", {30'd0, pc_o[1:0]}, 32'd0);
    end
  endtask

  task automatic t_branch(input logic [15:0] off);
    logic [31:0] link, tgt;
    if_instr_i = {16'h7400, off};
    step();
    link = rf_link_o;
    tgt  = link + {{14{off[15]}}, off, 2'b00};
    if_instr_i = 32'hDEAD_BEE0;
    br_taken_i = 1;
    #1;
    chk("R3 next", next_pc_o, tgt);
    chk("R6 br sel", {29'd0, pc_sel_o}, 32'd1);
    chk("R7 annul", {31'd0, annul_o}, 32'd1);
    step();
    br_taken_i = 0;
    chk("R3 pc", pc_o, tgt);
    chk("R7 squash", rf_instr_o, SQ);
  endtask

  task automatic t_jump();
    if_instr_i = 32'h1234_5678;
    jmp_i = 1; jmp_tgt_i = 32'h0000_1237;
    #1;
    chk("R4 next", next_pc_o, 32'h0000_1234);
    chk("R10 next align", {30'd0, next_pc_o[1:0]}, 32'd0);
    chk("R6 jmp sel", {29'd0, pc_sel_o}, 32'd2);
    step();
    jmp_i = 0;
    chk("R4 pc", pc_o, 32'h0000_1234);
    chk("R7 jmp squash", rf_instr_o, SQ);
  endtask

  task automatic t_priority();
    irq_i = 1; illop_i = 1; jmp_i = 1; br_taken_i = 1; jmp_tgt_i = 32'h40;
    #1;
    chk("R6 irq first", {29'd0, pc_sel_o}, 32'd4);
    chk("R5 irq vec", next_pc_o, 32'h8);
    chk("R7 no annul trap", {31'd0, annul_o}, 32'd0);
    irq_i = 0; #1;
    chk("R6 ill second", {29'd0, pc_sel_o}, 32'd3);
    chk("R5 ill vec", next_pc_o, 32'h4);
    illop_i = 0; #1;
    chk("R6 jmp over br", {29'd0, pc_sel_o}, 32'd2);
    chk("R6 jmp tgt", next_pc_o, 32'h40);
    clear_req();
  endtask

  task automatic t_stall();
    logic [31:0] p, ins, lk;
    step();
    p = pc_o; ins = rf_instr_o; lk = rf_link_o;
    stall_i = 1; if_instr_i = 32'h5555_AAA8;
    step(); step();
    chk("R8 pc hold", pc_o, p);
    chk("R8 instr hold", rf_instr_o, ins);
    chk("R8 link hold", rf_link_o, lk);
    irq_i = 1;
    step();
    irq_i = 0;
    chk("R9 trap under stall pc", pc_o, 32'h8);
    chk("R9 trap under stall instr", rf_instr_o, ins);
    stall_i = 0;
  endtask

  task automatic t_annul_stall();
    logic [31:0] tgt;
    if_instr_i = 32'h7400_0010;
    step();
    tgt = rf_link_o + 32'h40;
    stall_i = 1; br_taken_i = 1; if_instr_i = 32'hCAFE_0000;
    step();
    clear_req();
    chk("R9 pc loads target", pc_o, tgt);
    chk("R9 squash wins", rf_instr_o, SQ);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequential();
    t_branch(16'h0003);
    t_branch(16'hFFFE);
    t_jump();
    t_priority();
    t_stall();
    t_annul_stall();
    t_sequential();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule